// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block connects two byte-wide buses, called A and B, and passes data between them either straight through or from a storage register. Each bus has its own storage register, and each register has its own capture clock. The A register samples the A bus and can later be replayed onto B. The B register samples the B bus and can later be replayed onto A. A direction input picks which bus is driven. An active-low enable switches both drivers off. Two source selects choose, for each direction, between live data and stored data.

The default build has two lanes of eight bits. Each lane has its own full set of controls and clocks and shares nothing with the other lane except the reset. Every bidirectional pin is split into an input vector, an output vector and a per-lane drive enable, so the whole block stays synthesizable. An integration wrapper joins these signals into a tristate pad. Capture happens on every rising capture edge, even while the lane is isolated. This lets a lane snoop both buses while it drives neither.

Top module: `dual_lane_xcvr`

## Requirements
- R1: Each lane is independent. The controls, clocks and data of lane i (bits [8*i+7:8*i] of the data vectors, bit i of the control vectors) never affect the outputs of any other lane.
- R2: On a rising edge of `cap_a_clk[i]` with `rst` low, the A storage register of lane i loads that lane's `a_i` byte.
- R3: On a rising edge of `cap_b_clk[i]` with `rst` low, the B storage register of lane i loads that lane's `b_i` byte.
- R4: Capture takes place whatever the values of `en_n` and `to_b`. Both registers of a lane may be loaded at the same edge time.
- R5: While `en_n[i]` is 1, `a_drv[i]` and `b_drv[i]` are both 0.
- R6: While `en_n[i]` is 0 and `to_b[i]` is 0, `a_drv[i]` is 1 and `b_drv[i]` is 0. The lane's `a_o` byte equals the live `b_i` byte when `use_reg_b[i]` is 0, and the stored B byte when it is 1.
- R7: While `en_n[i]` is 0 and `to_b[i]` is 1, `b_drv[i]` is 1 and `a_drv[i]` is 0. The lane's `b_o` byte equals the live `a_i` byte when `use_reg_a[i]` is 0, and the stored A byte when it is 1.
- R8: `a_drv[i]` and `b_drv[i]` are never 1 together, so stored data never reaches both buses of a lane at once.
- R9: An output byte whose drive enable is 0 reads as all zeros.
- R10: A rising capture edge while `rst` is 1 clears that register to zero. Registers that are not clocked keep their contents.
- R11: The live path follows input changes with no clock edge. The stored path changes only at a capture edge of its own register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst | input | 1 | Synchronous active-high clear, sampled at each capture edge |
| cap_a_clk | input | LANES | Per-lane capture clock for the A storage register |
| cap_b_clk | input | LANES | Per-lane capture clock for the B storage register |
| en_n | input | LANES | Per-lane active-low output enable |
| to_b | input | LANES | Per-lane direction: 1 drives B from A, 0 drives A from B |
| use_reg_a | input | LANES | Source for the B bus: 0 live A, 1 stored A |
| use_reg_b | input | LANES | Source for the A bus: 0 live B, 1 stored B |
| a_i | input | LANES*LANE_W | Level seen on the A bus pins |
| a_o | output | LANES*LANE_W | Value driven onto the A bus |
| a_drv | output | LANES | Per-lane A bus drive enable |
| b_i | input | LANES*LANE_W | Level seen on the B bus pins |
| b_o | output | LANES*LANE_W | Value driven onto the B bus |
| b_drv | output | LANES | Per-lane B bus drive enable |

## Verification
The bench builds the block with its defaults of two lanes of eight bits. With two lanes, one lane can run in one direction while the other runs the opposite way from stored data. This exposes any control or clock that crosses between lanes. Eight bits allow complementary and alternating patterns, which expose swapped or stuck bits in the source multiplexers. The bench also captures while a lane is isolated, and applies reset to a single register, so both paths are reached through the ports.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    // Which side of a lane is currently driven
    typedef enum logic [1:0] {
        DRV_OFF  = 2'd0,
        DRV_TO_A = 2'd1,
        DRV_TO_B = 2'd2
    } drv_e;

    // Per-lane control bundle
    typedef struct packed {
        logic en_n;
        logic to_b;
        logic reg_a;
        logic reg_b;
    } lane_ctl_t;

endpackage

// File: rtl/xcvr_capture_reg.sv
module xcvr_capture_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] val;
    } cap_state_t;

    cap_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (rst) s_d.val = '0;
        else     s_d.val = din;
    end

    always_ff @(posedge clk) begin
        s_q <= s_d;
    end

    assign q = s_q.val;
endmodule

// File: rtl/xcvr_steer.sv
module xcvr_steer
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  lane_ctl_t    ctl,
    input  logic [W-1:0] a_live,
    input  logic [W-1:0] b_live,
    input  logic [W-1:0] a_store,
    input  logic [W-1:0] b_store,
    output logic [W-1:0] a_out,
    output logic         a_en,
    output logic [W-1:0] b_out,
    output logic         b_en
);
    drv_e         mode;
    logic [W-1:0] a_src;
    logic [W-1:0] b_src;

    always_comb begin
        mode = DRV_OFF;
        if (!ctl.en_n) mode = ctl.to_b ? DRV_TO_B : DRV_TO_A;
        a_src = ctl.reg_b ? b_store : b_live;
        b_src = ctl.reg_a ? a_store : a_live;
        a_en  = (mode == DRV_TO_A);
        b_en  = (mode == DRV_TO_B);
        a_out = a_en ? a_src : '0;
        b_out = b_en ? b_src : '0;
    end
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         rst,
    input  logic         clk_a,
    input  logic         clk_b,
    input  lane_ctl_t    ctl,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_en,
    output logic [W-1:0] b_out,
    output logic         b_en
);
    logic [W-1:0] a_held;
    logic [W-1:0] b_held;

    xcvr_capture_reg #(.W(W)) u_reg_a (
        .clk (clk_a),
        .rst (rst),
        .din (a_in),
        .q   (a_held)
    );

    xcvr_capture_reg #(.W(W)) u_reg_b (
        .clk (clk_b),
        .rst (rst),
        .din (b_in),
        .q   (b_held)
    );

    xcvr_steer #(.W(W)) u_steer (
        .ctl     (ctl),
        .a_live  (a_in),
        .b_live  (b_in),
        .a_store (a_held),
        .b_store (b_held),
        .a_out   (a_out),
        .a_en    (a_en),
        .b_out   (b_out),
        .b_en    (b_en)
    );
endmodule

// File: rtl/dual_lane_xcvr.sv
module dual_lane_xcvr
    import xcvr_pkg::*;
#(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input  logic                     rst,
    input  logic [LANES-1:0]         cap_a_clk,
    input  logic [LANES-1:0]         cap_b_clk,
    input  logic [LANES-1:0]         en_n,
    input  logic [LANES-1:0]         to_b,
    input  logic [LANES-1:0]         use_reg_a,
    input  logic [LANES-1:0]         use_reg_b,
    input  logic [LANES*LANE_W-1:0]  a_i,
    output logic [LANES*LANE_W-1:0]  a_o,
    output logic [LANES-1:0]         a_drv,
    input  logic [LANES*LANE_W-1:0]  b_i,
    output logic [LANES*LANE_W-1:0]  b_o,
    output logic [LANES-1:0]         b_drv
);
    localparam int BUS_W = LANES * LANE_W;

    lane_ctl_t [LANES-1:0] ctl;
    logic [BUS_W-1:0] a_o_w;
    logic [BUS_W-1:0] b_o_w;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign ctl[g] = '{en_n: en_n[g], to_b: to_b[g],
                          reg_a: use_reg_a[g], reg_b: use_reg_b[g]};

        xcvr_lane #(.W(LANE_W)) u_lane (
            .rst   (rst),
            .clk_a (cap_a_clk[g]),
            .clk_b (cap_b_clk[g]),
            .ctl   (ctl[g]),
            .a_in  (a_i[g*LANE_W +: LANE_W]),
            .b_in  (b_i[g*LANE_W +: LANE_W]),
            .a_out (a_o_w[g*LANE_W +: LANE_W]),
            .a_en  (a_drv[g]),
            .b_out (b_o_w[g*LANE_W +: LANE_W]),
            .b_en  (b_drv[g])
        );
    end

    assign a_o = a_o_w;
    assign b_o = b_o_w;
endmodule

// File: rtl/xcvr_chk.sv
module xcvr_chk #(
    parameter int LANES  = 2,
    parameter int LANE_W = 8
) (
    input logic                     rst,
    input logic [LANES-1:0]         cap_a_clk,
    input logic [LANES-1:0]         cap_b_clk,
    input logic [LANES-1:0]         en_n,
    input logic [LANES-1:0]         to_b,
    input logic [LANES-1:0]         use_reg_a,
    input logic [LANES-1:0]         use_reg_b,
    input logic [LANES*LANE_W-1:0]  a_i,
    input logic [LANES*LANE_W-1:0]  a_o,
    input logic [LANES-1:0]         a_drv,
    input logic [LANES*LANE_W-1:0]  b_i,
    input logic [LANES*LANE_W-1:0]  b_o,
    input logic [LANES-1:0]         b_drv
);
    for (genvar g = 0; g < LANES; g++) begin : g_chk
        // R8
        lane_excl_chk: assert property (@(posedge cap_a_clk[g]) disable iff (rst)
            !(a_drv[g] && b_drv[g]));

        // R5
        iso_chk: assert property (@(posedge cap_b_clk[g]) disable iff (rst)
            en_n[g] |-> (!a_drv[g] && !b_drv[g]));

        // R6
        a_side_drive_chk: assert property (@(posedge cap_a_clk[g]) disable iff (rst)
            (!en_n[g] && !to_b[g]) |-> (a_drv[g] && !b_drv[g]));

        // R6
        live_ba_chk: assert property (@(posedge cap_b_clk[g]) disable iff (rst)
            (!en_n[g] && !to_b[g] && !use_reg_b[g])
                |-> (a_o[g*LANE_W +: LANE_W] == b_i[g*LANE_W +: LANE_W]));

        // R7
        b_side_drive_chk: assert property (@(posedge cap_b_clk[g]) disable iff (rst)
            (!en_n[g] && to_b[g]) |-> (b_drv[g] && !a_drv[g]));

        // R7
        live_ab_chk: assert property (@(posedge cap_a_clk[g]) disable iff (rst)
            (!en_n[g] && to_b[g] && !use_reg_a[g])
                |-> (b_o[g*LANE_W +: LANE_W] == a_i[g*LANE_W +: LANE_W]));
    end
endmodule

bind dual_lane_xcvr xcvr_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (
    .rst       (rst),
    .cap_a_clk (cap_a_clk),
    .cap_b_clk (cap_b_clk),
    .en_n      (en_n),
    .to_b      (to_b),
    .use_reg_a (use_reg_a),
    .use_reg_b (use_reg_b),
    .a_i       (a_i),
    .a_o       (a_o),
    .a_drv     (a_drv),
    .b_i       (b_i),
    .b_o       (b_o),
    .b_drv     (b_drv)
);

// File: tb/tb_dual_lane_xcvr.sv
module tb_dual_lane_xcvr;
    localparam int L = 2;
    localparam int W = 8;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic           rst = 1'b1;
    logic [L-1:0]   cap_a_clk = '0, cap_b_clk = '0;
    logic [L-1:0]   en_n = '1, to_b = '0, use_reg_a = '0, use_reg_b = '0;
    logic [L*W-1:0] a_i = '0, b_i = '0;
    logic [L*W-1:0] a_o, b_o;
    logic [L-1:0]   a_drv, b_drv;

    dual_lane_xcvr #(.LANES(L), .LANE_W(W)) dut (
        .rst(rst), .cap_a_clk(cap_a_clk), .cap_b_clk(cap_b_clk),
        .en_n(en_n), .to_b(to_b), .use_reg_a(use_reg_a), .use_reg_b(use_reg_b),
        .a_i(a_i), .a_o(a_o), .a_drv(a_drv),
        .b_i(b_i), .b_o(b_o), .b_drv(b_drv)
    );

    typedef struct {
        int          lane;
        logic        ad;
        logic [W-1:0] av;
        logic        bd;
        logic [W-1:0] bv;
        string       req;
    } exp_t;

    exp_t         sb_q[$];
    logic [W-1:0] ma[L];
    logic [W-1:0] mb[L];
    int           n_chk = 0;
    int           n_fail = 0;
    bit           done = 0;

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // Expected outputs from the requirements, then wait one bench cycle
    task automatic settle(string req);
        for (int l = 0; l < L; l++) begin
            exp_t e;
            e.lane = l;
            e.req  = req;
            e.ad   = !en_n[l] && !to_b[l];
            e.bd   = !en_n[l] &&  to_b[l];
            e.av   = e.ad ? (use_reg_b[l] ? mb[l] : b_i[l*W +: W]) : '0;
            e.bv   = e.bd ? (use_reg_a[l] ? ma[l] : a_i[l*W +: W]) : '0;
            sb_q.push_back(e);
        end
        @(posedge clk); #1;
    endtask

    // Rising capture edges on the masked lanes; model updates from R2/R3/R10
    task automatic pulse(logic [L-1:0] mask_a, logic [L-1:0] mask_b);
        #1;
        for (int l = 0; l < L; l++) begin
            if (mask_a[l]) ma[l] = rst ? '0 : a_i[l*W +: W];
            if (mask_b[l]) mb[l] = rst ? '0 : b_i[l*W +: W];
        end
        cap_a_clk = mask_a;
        cap_b_clk = mask_b;
        @(posedge clk); #1;
        cap_a_clk = '0;
        cap_b_clk = '0;
        #1;
    endtask

    task automatic check(string req, string what, logic [W:0] act, logic [W:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: pop expected items away from the bench clock edge
    always @(negedge clk) begin
        while (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(e.req, $sformatf("lane%0d a", e.lane),
                  {a_drv[e.lane], a_o[e.lane*W +: W]}, {e.ad, e.av});
            check(e.req, $sformatf("lane%0d b", e.lane),
                  {b_drv[e.lane], b_o[e.lane*W +: W]}, {e.bd, e.bv});
            check("R8", $sformatf("lane%0d both drivers", e.lane),
                  {{W{1'b0}}, a_drv[e.lane] & b_drv[e.lane]}, '0);
        end
    end

    initial begin
        #100000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        for (int l = 0; l < L; l++) begin ma[l] = 'x; mb[l] = 'x; end
        a_i = 16'h1234; b_i = 16'h5678;
        repeat (2) @(posedge clk); #1;
        // R10: reset clears all stored registers
        pulse('1, '1);
        rst = 1'b0;
        // R5 R9: isolated lanes drive nothing and read zero
        settle("R5_R9_reset");
        // R10: stored values read back as zero
        en_n = '0; to_b = '1; use_reg_a = '1;
        settle("R10_a");
        to_b = '0; use_reg_b = '1;
        settle("R10_b");
        // R7: live A to B, two patterns, then R11 change with no clock
        to_b = '1; use_reg_a = '0;
        a_i = 16'hA55A;
        settle("R7_live");
        a_i = 16'h0FF0;
        settle("R11_live_follow");
        // R6: live B to A
        to_b = '0; use_reg_b = '0;
        b_i = 16'hC33C;
        settle("R6_live");
        // R4 R2: capture A while isolated
        en_n = '1;
        a_i = 16'h3C96;
        pulse('1, '0);
        settle("R4_iso");
        a_i = 16'hFFFF;
        en_n = '0; to_b = '1; use_reg_a = '1;
        settle("R2_R11_stored_a");
        // R4 R3: capture B while B is being driven
        b_i = 16'h8142;
        pulse('0, '1);
        b_i = 16'h0000;
        to_b = '0; use_reg_b = '1;
        settle("R3_stored_b");
        // R4: both registers loaded at the same time
        en_n = '1;
        a_i = 16'h6699; b_i = 16'h2277;
        pulse('1, '1);
        a_i = 16'h0101; b_i = 16'h1010;
        en_n = '0; to_b = '1;
        settle("R4_both_a");
        to_b = '0;
        settle("R4_both_b");
        // R1: lanes in opposite modes, clock only lane 1
        to_b = 2'b01; use_reg_a = 2'b00; use_reg_b = 2'b10;
        a_i = 16'hEE11; b_i = 16'hDD22;
        pulse('0, 2'b10);
        b_i = 16'h4400;
        settle("R1_independent");
        // R10: reset one register of lane 0 only; others keep contents
        rst = 1'b1;
        pulse(2'b01, '0);
        rst = 1'b0;
        to_b = '1; use_reg_a = '1; use_reg_b = '1;
        settle("R10_partial_a");
        to_b = '0;
        settle("R10_partial_b");
        // R5: isolation after activity
        en_n = '1;
        settle("R5_isolate");
        repeat (2) @(posedge clk);
        finish_run();
    end
endmodule